// File: doc/BRIEF.md
# Data-Ready Gated SPI Host

This block is the host end of a byte-wide SPI link to a slave that can only talk at certain times. The slave raises a data-ready line when it can accept a transfer. The host asks for a transfer by handing a command byte over a valid/ready request port. The block waits until data-ready has been stable for a guard time. It then lowers the select line, waits a lead time, and clocks eight bits in SPI mode 3: the clock idles high, MOSI changes after falling edges, MISO is taken during the high phase, and the MSB goes first. It keeps select low for a hold time after the last clock, then reports the received byte on a response port.

The slave's answer always belongs to the command of the previous transfer. Each response therefore also carries the command byte it answers. After reset the block waits a long start-up interval before it accepts any request. If data-ready does not qualify within a timeout, the request is dropped and the response is flagged as an error. Every delay and the clock half-period are parameters counted in system-clock cycles. Data-ready and MISO each pass through a two-flop synchronizer before use.

Top module: `hsk_spi_host`

## Requirements
- R1: While reset is held and on the first cycle after it is released, spi_ss_n=1, spi_sck=1, req_ready=0 and rsp_valid=0. spi_sck only changes while spi_ss_n is 0.
- R2: req_ready stays 0 for BOOT_CYC cycles after reset is released, then goes to 1.
- R3: A transfer has exactly 8 clock cycles, each a fall followed by a rise. The command byte appears on spi_mosi MSB first and can be read on each rising edge. spi_mosi does not change while spi_sck is high during a transfer.
- R4: rsp_data holds the 8 spi_miso levels present during the 8 high phases, with the first one in bit 7.
- R5: spi_ss_n falls only after the synchronized data-ready level has been high for GUARD_CYC consecutive cycles since the request was accepted. A low level restarts that count.
- R6: The first falling edge of spi_sck comes exactly LEAD_CYC cycles after spi_ss_n falls.
- R7: Every low phase and every high phase of spi_sck inside a transfer lasts exactly HALF_CYC cycles.
- R8: After the last rising edge, spi_ss_n stays 0 and spi_mosi stays unchanged for at least HOLD_CYC cycles.
- R9: On a completed transfer, rsp_err=0 and rsp_cmd carries the command byte of the previous completed transfer (8'h00 for the first transfer after reset).
- R10: If the guard of R5 is not met within TOUT_CYC cycles of acceptance, the block gives a response with rsp_err=1, rsp_data=8'h00 and rsp_cmd set to the dropped command. spi_ss_n stays high, and the dropped command does not change the rsp_cmd of later responses.
- R11: req_ready is 1 only while the block is idle. Each accepted request produces exactly one rsp_valid pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command byte offered |
| req_ready | output | 1 | Block idle and accepting a command |
| req_cmd | input | 8 | Command byte to send |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a timeout drop |
| rsp_data | output | 8 | Byte received from the slave |
| rsp_cmd | output | 8 | Command that rsp_data answers (or the dropped command) |
| slv_rdy | input | 1 | Slave data-ready line, asynchronous |
| spi_ss_n | output | 1 | Slave select, active low |
| spi_sck | output | 1 | SPI clock, idle high |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave, asynchronous |

## Verification
The hardest case to reach from the ports is a short high pulse on data-ready after a request has been accepted. The pulse must be long enough to pass the synchronizer but shorter than the guard, and the guard count must restart from zero when it ends. The stimulus raises data-ready for five cycles, drops it, and raises it again. The check is that select falls at least GUARD_CYC cycles after the second rise. A second case is a timeout followed by a normal transfer. It shows that the dropped command never enters the previous-command history.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } seq_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int PW = W * STAGES;

  logic [PW-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PW-W-1:0], d};
      end
    end
  endgenerate

  assign q = pipe[PW-1 -: W];

endmodule

// File: rtl/hsk_seq.sv
module hsk_seq
  import hsk_pkg::*;
#(
  parameter int BOOT_CYC  = 55_000_000,
  parameter int GUARD_CYC = 1_500,
  parameter int LEAD_CYC  = 1_500,
  parameter int HALF_CYC  = 2_000,
  parameter int HOLD_CYC  = 1_500,
  parameter int TOUT_CYC  = 10_000_000,
  parameter int NBITS     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic rdy_s,
  output logic ready,
  output logic accept,
  output logic ss_n,
  output logic sck,
  output logic shift_stb,
  output logic sample_stb,
  output logic done_stb,
  output logic fail_stb
);

  localparam int MAXC = imax(imax(imax(BOOT_CYC, TOUT_CYC), imax(LEAD_CYC, HALF_CYC)), HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(GUARD_CYC + 1);
  localparam int BW   = $clog2(NBITS);

  localparam logic [CW-1:0] BOOT_END  = CW'(BOOT_CYC - 1);
  localparam logic [CW-1:0] TOUT_END  = CW'(TOUT_CYC - 1);
  localparam logic [CW-1:0] LEAD_END  = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] HALF_END  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CYC - 1);
  localparam logic [RW-1:0] GUARD_END = RW'(GUARD_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(NBITS - 1);

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run;
  logic [BW-1:0] bitn;

  assign ready  = (st == ST_IDLE);
  assign accept = ready && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_BOOT;
      cnt        <= '0;
      run        <= '0;
      bitn       <= '0;
      ss_n       <= 1'b1;
      sck        <= 1'b1;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      done_stb   <= 1'b0;
      fail_stb   <= 1'b0;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      done_stb   <= 1'b0;
      fail_stb   <= 1'b0;
      case (st)
        ST_BOOT: begin
          if (cnt == BOOT_END) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            st  <= ST_WAIT;
            cnt <= '0;
            run <= '0;
          end
        end
        ST_WAIT: begin
          if (rdy_s && run == GUARD_END) begin
            st   <= ST_LEAD;
            ss_n <= 1'b0;
            cnt  <= '0;
          end else if (cnt == TOUT_END) begin
            st       <= ST_IDLE;
            fail_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            run <= rdy_s ? run + 1'b1 : '0;
          end
        end
        ST_LEAD: begin
          if (cnt == LEAD_END) begin
            st   <= ST_LOW;
            sck  <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt == HALF_END) begin
            st  <= ST_HIGH;
            sck <= 1'b1;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == HALF_END) begin
            sample_stb <= 1'b1;
            cnt        <= '0;
            if (bitn == LAST_BIT) begin
              st <= ST_HOLD;
            end else begin
              st        <= ST_LOW;
              sck       <= 1'b0;
              shift_stb <= 1'b1;
              bitn      <= bitn + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == HOLD_END) begin
            st       <= ST_IDLE;
            ss_n     <= 1'b1;
            done_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // select may only fall when the synchronized ready level was high
  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ss_n) |-> $past(rdy_s));

  // no new request is taken while a frame is open
  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !ss_n |-> !ready);

endmodule

// File: rtl/hsk_shift.sv
module hsk_shift #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] cmd,
  input  logic             shift_stb,
  input  logic             sample_stb,
  input  logic             miso_s,
  output logic             mosi,
  output logic [NBITS-1:0] rx,
  output logic [NBITS-1:0] cmd_q
);

  logic [NBITS-2:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= '0;
      mosi  <= 1'b0;
      rx    <= '0;
      cmd_q <= '0;
    end else begin
      if (load) begin
        cmd_q <= cmd;
        mosi  <= cmd[NBITS-1];
        tx    <= cmd[NBITS-2:0];
      end else if (shift_stb) begin
        mosi <= tx[NBITS-2];
        tx   <= {tx[NBITS-3:0], 1'b0};
      end
      if (sample_stb) rx <= {rx[NBITS-2:0], miso_s};
    end
  end

endmodule

// File: rtl/hsk_spi_host.sv
module hsk_spi_host #(
  parameter int BOOT_CYC  = 55_000_000,
  parameter int GUARD_CYC = 1_500,
  parameter int LEAD_CYC  = 1_500,
  parameter int HALF_CYC  = 2_000,
  parameter int HOLD_CYC  = 1_500,
  parameter int TOUT_CYC  = 10_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_cmd,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic [7:0] rsp_data,
  output logic [7:0] rsp_cmd,
  input  logic       slv_rdy,
  output logic       spi_ss_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int NBITS = 8;

  logic             rdy_s, miso_s;
  logic             accept, shift_stb, sample_stb, done_stb, fail_stb;
  logic [NBITS-1:0] rx, cmd_q, prev_cmd;

  hsk_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({slv_rdy, spi_miso}),
    .q   ({rdy_s, miso_s})
  );

  hsk_seq #(
    .BOOT_CYC (BOOT_CYC),
    .GUARD_CYC(GUARD_CYC),
    .LEAD_CYC (LEAD_CYC),
    .HALF_CYC (HALF_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TOUT_CYC (TOUT_CYC),
    .NBITS    (NBITS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rdy_s     (rdy_s),
    .ready     (req_ready),
    .accept    (accept),
    .ss_n      (spi_ss_n),
    .sck       (spi_sck),
    .shift_stb (shift_stb),
    .sample_stb(sample_stb),
    .done_stb  (done_stb),
    .fail_stb  (fail_stb)
  );

  hsk_shift #(.NBITS(NBITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .cmd       (req_cmd),
    .shift_stb (shift_stb),
    .sample_stb(sample_stb),
    .miso_s    (miso_s),
    .mosi      (spi_mosi),
    .rx        (rx),
    .cmd_q     (cmd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      rsp_cmd   <= '0;
      prev_cmd  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (done_stb) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b0;
        rsp_data  <= rx;
        rsp_cmd   <= prev_cmd;
        prev_cmd  <= cmd_q;
      end else if (fail_stb) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_data  <= '0;
        rsp_cmd   <= cmd_q;
      end
    end
  end

  // clock idles high whenever the frame is closed
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    spi_ss_n |-> spi_sck);

  // clock edges only inside a frame
  assert_sck_framed_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_sck) |-> !spi_ss_n);

  // data steady across the high phase
  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (!spi_ss_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // response strobe lasts one cycle
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/hsk_spi_host_test.sv
module hsk_spi_host_test;

  localparam int BOOT  = 200;
  localparam int GUARD = 20;
  localparam int LEAD  = 15;
  localparam int HALF  = 10;
  localparam int HOLD  = 14;
  localparam int TOUT  = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_cmd = 8'h00;
  logic       slv_rdy = 1'b0;
  logic       spi_miso = 1'b0;
  logic       req_ready, rsp_valid, rsp_err, spi_ss_n, spi_sck, spi_mosi;
  logic [7:0] rsp_data, rsp_cmd;

  always #5 clk = ~clk;

  hsk_spi_host #(
    .BOOT_CYC(BOOT), .GUARD_CYC(GUARD), .LEAD_CYC(LEAD),
    .HALF_CYC(HALF), .HOLD_CYC(HOLD), .TOUT_CYC(TOUT)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .rsp_cmd(rsp_cmd), .slv_rdy(slv_rdy),
    .spi_ss_n(spi_ss_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // slave model and port monitor, all sampled on the falling system clock
  int cyc = 0, t_rdy_rise = 0, t_ss_fall = 0, t_ss_rise = 0, t_edge = 0;
  int t_last_rise = 0, t_rsp = 0, lead = 0, ph_min = 0, ph_max = 0;
  int nedge = 0, nfall = 0, n_rsp = 0, n_ssfall = 0, rsp_width = 0;
  bit mosi_bad = 0, hold_bad = 0, got_rsp = 0;
  logic [7:0] cap = 0, resp_byte = 0, got_data = 0, got_cmd = 0;
  logic got_err = 0;
  logic p_rdy = 0, p_ss = 1, p_sck = 1, p_mosi = 0, p_rv = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (slv_rdy && !p_rdy) t_rdy_rise = cyc;
    if (!spi_ss_n && p_ss) begin
      t_ss_fall = cyc; t_edge = cyc; nedge = 0; nfall = 0; cap = 0;
      ph_min = 1 << 20; ph_max = 0; mosi_bad = 0; hold_bad = 0;
      n_ssfall++;
      spi_miso = resp_byte[7];
    end
    if (!spi_ss_n && spi_sck != p_sck) begin
      if (nedge == 0) lead = cyc - t_edge;
      else begin
        if (cyc - t_edge < ph_min) ph_min = cyc - t_edge;
        if (cyc - t_edge > ph_max) ph_max = cyc - t_edge;
      end
      t_edge = cyc;
      nedge++;
      if (spi_sck) begin
        cap = {cap[6:0], spi_mosi};
        t_last_rise = cyc;
      end else begin
        if (nfall > 0 && nfall < 8) spi_miso = resp_byte[7 - nfall];
        nfall++;
      end
    end
    if (!spi_ss_n && spi_sck && p_sck && spi_mosi != p_mosi && nedge < 16) mosi_bad = 1;
    if (!spi_ss_n && nedge == 16 && spi_mosi != p_mosi) hold_bad = 1;
    if (spi_ss_n && !p_ss) t_ss_rise = cyc;
    if (rsp_valid) begin
      if (!p_rv) begin
        n_rsp++; got_rsp = 1; t_rsp = cyc;
        got_data = rsp_data; got_cmd = rsp_cmd; got_err = rsp_err;
        rsp_width = 1;
      end else rsp_width++;
    end
    p_rdy = slv_rdy; p_ss = spi_ss_n; p_sck = spi_sck; p_mosi = spi_mosi; p_rv = rsp_valid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int t_acc = 0;

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_cmd   = c;
    @(negedge clk);
    t_acc     = cyc;
    req_valid = 1'b0;
    req_cmd   = 8'h00;
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 5000 && !got_rsp; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(spi_ss_n == 1 && spi_sck == 1, "R1 idle lines in reset", {spi_ss_n, spi_sck}, 3);
    check(req_ready == 0 && rsp_valid == 0, "R1 handshake in reset", {req_ready, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(spi_ss_n == 1 && spi_sck == 1 && req_ready == 0, "R1 after release",
          {spi_ss_n, spi_sck, req_ready}, 6);
  endtask

  task automatic t_startup();
    int start = cyc - 1;
    repeat (BOOT - 4) @(negedge clk);
    check(req_ready == 0, "R2 ready low during start-up", req_ready, 0);
    for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
    check(req_ready == 1 && (cyc - start) >= BOOT && (cyc - start) <= BOOT + 3,
          "R2 ready time", cyc - start, BOOT);
  endtask

  task automatic t_xfer(input logic [7:0] c, input logic [7:0] reply, input bit pre_rdy,
                        input int rdy_delay, input logic [7:0] exp_cmd);
    int nr = n_rsp;
    int ref_t;
    resp_byte = reply;
    got_rsp = 0;
    slv_rdy = pre_rdy;
    send(c);
    check(spi_ss_n == 1 && req_ready == 0, "R11 busy after accept", req_ready, 0);
    if (!pre_rdy) begin
      repeat (rdy_delay) @(negedge clk);
      slv_rdy = 1'b1;
    end
    wait_rsp();
    slv_rdy = 1'b0;
    ref_t = pre_rdy ? t_acc : t_rdy_rise;
    check(got_rsp && got_err == 0, "R9 completed response", got_err, 0);
    check(cap == c && nedge == 16, "R3 command bits on rising edges", cap, c);
    check(!mosi_bad, "R3 mosi steady while clock high", mosi_bad, 0);
    check(got_data == reply, "R4 received byte", got_data, reply);
    check(got_cmd == exp_cmd, "R9 previous command label", got_cmd, exp_cmd);
    check(t_ss_fall - ref_t >= GUARD, "R5 ready-to-select guard", t_ss_fall - ref_t, GUARD);
    check(lead == LEAD, "R6 select-to-clock lead", lead, LEAD);
    check(ph_min == HALF && ph_max == HALF, "R7 clock phases", ph_max, HALF);
    check(t_ss_rise - t_last_rise >= HOLD && !hold_bad, "R8 hold after last edge",
          t_ss_rise - t_last_rise, HOLD);
    check(n_rsp == nr + 1 && rsp_width == 1, "R11 one response pulse", n_rsp - nr, 1);
  endtask

  task automatic t_glitch(input logic [7:0] c, input logic [7:0] reply, input logic [7:0] exp_cmd);
    resp_byte = reply;
    got_rsp = 0;
    slv_rdy = 1'b0;
    send(c);
    repeat (10) @(negedge clk);
    slv_rdy = 1'b1;
    repeat (5) @(negedge clk);
    slv_rdy = 1'b0;
    repeat (4) @(negedge clk);
    slv_rdy = 1'b1;
    wait_rsp();
    slv_rdy = 1'b0;
    check(t_ss_fall > t_rdy_rise && t_ss_fall - t_rdy_rise >= GUARD,
          "R5 guard restarts after short pulse", t_ss_fall - t_rdy_rise, GUARD);
    check(got_data == reply && got_cmd == exp_cmd, "R9 response after glitch", got_cmd, exp_cmd);
  endtask

  task automatic t_timeout(input logic [7:0] c);
    int nss = n_ssfall;
    got_rsp = 0;
    slv_rdy = 1'b0;
    send(c);
    wait_rsp();
    check(got_rsp && got_err == 1, "R10 error flag", got_err, 1);
    check(got_data == 8'h00 && got_cmd == c, "R10 dropped command label", got_cmd, c);
    check(n_ssfall == nss, "R10 select never asserted", n_ssfall - nss, 0);
    check(t_rsp - t_acc >= TOUT && t_rsp - t_acc <= TOUT + 4, "R10 timeout length",
          t_rsp - t_acc, TOUT);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_xfer(8'hA5, 8'h3C, 1'b0, 30, 8'h00);
    t_xfer(8'h5A, 8'hC3, 1'b1, 0, 8'hA5);
    t_xfer(8'h81, 8'h7E, 1'b0, 3, 8'h5A);
    t_glitch(8'h0F, 8'hF0, 8'h81);
    t_timeout(8'h77);
    t_xfer(8'hE1, 8'h1E, 1'b0, 12, 8'h0F);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule